// File: doc/BRIEF.md
# Write-Completion Status Read Logic

This block sits on the read path of a byte-wide nonvolatile memory whose writes run as a self-timed internal programming cycle. While that cycle runs, the host cannot get array contents back. Instead, every read returns a status word that lets software detect completion in two independent ways.

The first is a polarity flag. When the host reads the location it wrote last, the top data bit comes back as the inverse of the bit it wrote. The second is an alternating flag. The next-to-top bit changes value on every read that happens while programming is in progress.

The block keeps a copy of the last captured write: its address, its data, and whether the write was legal. It watches a busy input from the programming sequencer. A qualified read is a read strobe with chip enable and output enable both low (active-low). For each qualified read, the block registers either the array data or the status word. The result appears on the output one clock later, together with an output-valid flag.

Top module: `wstat_read_unit`

## Requirements
- R1: While reset (`rst_n` low) is applied, and on the first clock after it, `dout` is all zeros and `dout_oe` is 0.
- R2: A qualified read is `rd_stb`=1 with `ce_n`=0 and `oe_n`=0 at a rising clock edge. After a qualified read, `dout_oe` is 1 for exactly the following cycle. After any other cycle, `dout_oe` is 0 and `dout` is all zeros.
- R3: A qualified read with `busy_i`=0 returns `arr_rdata`, sampled at that edge, unchanged on `dout` in the next cycle.
- R4: A qualified read with `busy_i`=1 is a status read. If `rd_addr` equals the last captured address and that capture was legal (`wr_illegal`=0), `dout[7]` is the inverse of bit 7 of the last captured data.
- R5: During status reads, `dout[6]` takes the opposite value on each successive status read. Strobes that are not qualified do not advance it. Its value at the first status read is not specified.
- R6: During a status read, `dout[5:0]` are all zero.
- R7: During a status read, `dout[7]` equals `arr_rdata[7]` in two cases: the address does not match the last capture, or the last capture was marked illegal. The same holds after reset, before any capture.
- R8: The alternating flag holds its value while `busy_i`=0. The first status read after an idle period returns the opposite of the last status read before it.
- R9: `wr_cap`=1 at an edge stores `wr_addr`, `wr_data` and `wr_illegal`. A qualified read at the same edge still uses the previously stored values, and later reads use the new ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_cap | input | 1 | Capture the last-written byte this cycle |
| wr_illegal | input | 1 | Captured write was refused by protection; disables polarity polling |
| wr_addr | input | ADDR_W | Address of the captured write |
| wr_data | input | DATA_W | Data of the captured write |
| busy_i | input | 1 | Internal programming cycle in progress |
| rd_stb | input | 1 | Read access strobe |
| ce_n | input | 1 | Chip enable, active low |
| oe_n | input | 1 | Output enable, active low |
| rd_addr | input | ADDR_W | Read address |
| arr_rdata | input | DATA_W | Array data for `rd_addr` |
| dout | output | DATA_W | Registered read data or status word |
| dout_oe | output | 1 | `dout` carries a valid read result |

## Verification
The bench builds the block with its default parameters: a 17-bit address and an 8-bit data path. With these, the polarity flag is bit 7, the alternating flag is bit 6, and the six reserved bits are fully visible. The read addresses are drawn from a small set of three locations, so address matches and mismatches against the stored write both occur often. The random phase also covers illegal captures and captures that land on the same edge as a read.

// File: rtl/wsr_pkg.sv
package wsr_pkg;

  typedef enum logic [1:0] {
    RD_NONE   = 2'd0,
    RD_ARRAY  = 2'd1,
    RD_STATUS = 2'd2
  } rd_kind_e;

  // Classify one access: nothing, plain array read, or in-progress status read.
  function automatic rd_kind_e classify(input logic qualified, input logic busy);
    if (!qualified) return RD_NONE;
    return busy ? RD_STATUS : RD_ARRAY;
  endfunction

  // Polarity flag: inverted last-written bit only on a legal address hit.
  function automatic logic poll_flag(input logic hit, input logic enabled,
                                     input logic last_msb, input logic arr_msb);
    return (hit && enabled) ? ~last_msb : arr_msb;
  endfunction

endpackage

// File: rtl/wsr_last_write.sv
module wsr_last_write #(
  parameter int ADDR_W = 17,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cap,
  input  logic              illegal,
  input  logic [ADDR_W-1:0] cap_addr,
  input  logic [DATA_W-1:0] cap_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] last_data,
  output logic              poll_en,
  output logic              addr_hit
);
  logic [ADDR_W-1:0] last_addr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      last_addr <= '0;
      last_data <= '0;
      poll_en   <= 1'b0;
    end else if (cap) begin
      last_addr <= cap_addr;
      last_data <= cap_data;
      poll_en   <= ~illegal;
    end
  end

  assign addr_hit = (rd_addr == last_addr);

  // R9: a capture is visible on the following cycle
  a_r9_capture_stores: assert property (@(posedge clk) disable iff (!rst_n)
    cap |=> (last_data == $past(cap_data)) && (poll_en == !$past(illegal)));

  // R9: without a capture the stored byte is held
  a_r9_hold_without_capture: assert property (@(posedge clk) disable iff (!rst_n)
    !cap |=> $stable(last_data) && $stable(poll_en));

endmodule

// File: rtl/wsr_toggle.sv
module wsr_toggle (
  input  logic clk,
  input  logic rst_n,
  input  logic adv,
  output logic tog_q
);
  always_ff @(posedge clk) begin
    if (!rst_n)   tog_q <= 1'b0;
    else if (adv) tog_q <= ~tog_q;
  end

  // R5: each status read advances the flag
  a_r5_flips_per_status_read: assert property (@(posedge clk) disable iff (!rst_n)
    adv |=> tog_q != $past(tog_q));

  // R8: no status read, no change
  a_r8_holds_otherwise: assert property (@(posedge clk) disable iff (!rst_n)
    !adv |=> $stable(tog_q));

endmodule

// File: rtl/wstat_read_unit.sv
module wstat_read_unit #(
  parameter int ADDR_W = 17,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_cap,
  input  logic              wr_illegal,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              busy_i,
  input  logic              rd_stb,
  input  logic              ce_n,
  input  logic              oe_n,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic [DATA_W-1:0] arr_rdata,
  output logic [DATA_W-1:0] dout,
  output logic              dout_oe
);
  import wsr_pkg::*;

  localparam int POLL_BIT = DATA_W - 1;
  localparam int TOG_BIT  = DATA_W - 2;
  localparam int RSV_W    = DATA_W - 2;

  // Named internal events for the assertions
  logic              rd_valid;
  logic              status_rd;
  rd_kind_e          rd_kind;
  logic [DATA_W-1:0] last_data;
  logic              poll_en;
  logic              addr_hit;
  logic              tog_q;
  logic [DATA_W-1:0] status_word;

  assign rd_valid  = rd_stb & ~ce_n & ~oe_n;
  assign rd_kind   = classify(rd_valid, busy_i);
  assign status_rd = (rd_kind == RD_STATUS);

  wsr_last_write #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_last (
    .clk(clk), .rst_n(rst_n), .cap(wr_cap), .illegal(wr_illegal),
    .cap_addr(wr_addr), .cap_data(wr_data), .rd_addr(rd_addr),
    .last_data(last_data), .poll_en(poll_en), .addr_hit(addr_hit)
  );

  wsr_toggle u_tog (
    .clk(clk), .rst_n(rst_n), .adv(status_rd), .tog_q(tog_q)
  );

  always_comb begin
    status_word           = '0;
    status_word[POLL_BIT] = poll_flag(addr_hit, poll_en,
                                      last_data[POLL_BIT], arr_rdata[POLL_BIT]);
    status_word[TOG_BIT]  = tog_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dout    <= '0;
      dout_oe <= 1'b0;
    end else begin
      unique case (rd_kind)
        RD_ARRAY: begin
          dout    <= arr_rdata;
          dout_oe <= 1'b1;
        end
        RD_STATUS: begin
          dout    <= status_word;
          dout_oe <= 1'b1;
        end
        default: begin
          dout    <= '0;
          dout_oe <= 1'b0;
        end
      endcase
    end
  end

  // R2: valid only right after a qualified read
  a_r2_oe_after_read: assert property (@(posedge clk) disable iff (!rst_n)
    dout_oe |-> $past(rd_valid));

  // R2: disabled output is quiet
  a_r2_quiet_when_disabled: assert property (@(posedge clk) disable iff (!rst_n)
    !dout_oe |-> dout == '0);

  // R3: idle reads pass array data through
  a_r3_array_pass: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && !busy_i) |=> dout == $past(arr_rdata));

  // R4: polarity flag inverts the last written top bit
  a_r4_poll_inverts: assert property (@(posedge clk) disable iff (!rst_n)
    (status_rd && addr_hit && poll_en) |=> dout[POLL_BIT] != $past(last_data[POLL_BIT]));

  // R6: reserved status bits read zero
  a_r6_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
    status_rd |=> dout[RSV_W-1:0] == '0);

  // R7: no polling on a mismatch or an illegal capture
  a_r7_no_poll: assert property (@(posedge clk) disable iff (!rst_n)
    (status_rd && !(addr_hit && poll_en)) |=> dout[POLL_BIT] == $past(arr_rdata[POLL_BIT]));

endmodule

// File: tb/wstat_read_unit_tb_top.sv
module wstat_read_unit_tb_top;
  localparam int AW = 17;
  localparam int DW = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wr_cap = 1'b0, wr_illegal = 1'b0, busy_i = 1'b0;
  logic          rd_stb = 1'b0, ce_n = 1'b1, oe_n = 1'b1;
  logic [AW-1:0] wr_addr = '0, rd_addr = '0;
  logic [DW-1:0] wr_data = '0, arr_rdata = '0;
  logic [DW-1:0] dout;
  logic          dout_oe;

  always #5 clk = ~clk;

  wstat_read_unit #(.ADDR_W(AW), .DATA_W(DW)) dut_i (
    .clk(clk), .rst_n(rst_n), .wr_cap(wr_cap), .wr_illegal(wr_illegal),
    .wr_addr(wr_addr), .wr_data(wr_data), .busy_i(busy_i), .rd_stb(rd_stb),
    .ce_n(ce_n), .oe_n(oe_n), .rd_addr(rd_addr), .arr_rdata(arr_rdata),
    .dout(dout), .dout_oe(dout_oe)
  );

  int checks = 0;
  int errors = 0;

  task automatic chk(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // Behavioural reference model
  logic [AW-1:0] m_addr = '0;
  logic [DW-1:0] m_data = '0;
  bit            m_poll = 0;
  bit            in_rst = 1;
  int            kind = 0;
  logic [DW-1:0] exp_d = '0;
  bit            exp7 = 0;
  string         tag7 = "R7";
  string         tagd = "R3";
  bit            gap = 0, r8_now = 0, same_prev = 0, r9_now = 0;
  bit            t_known = 0, t_last = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      in_rst = 1; kind = 0; m_poll = 0; m_addr = '0; m_data = '0;
      t_known = 0; gap = 0; same_prev = 0;
    end else begin
      bit rv;
      in_rst = 0;
      rv = rd_stb && !ce_n && !oe_n;
      if (!busy_i) gap = 1;
      r9_now = same_prev;
      same_prev = wr_cap && rv;
      if (rv && busy_i) begin
        bit hit;
        kind = 2;
        hit = (rd_addr == m_addr) && m_poll;
        exp7 = hit ? ~m_data[7] : arr_rdata[7];
        tag7 = r9_now ? "R9" : (hit ? "R4" : "R7");
        r8_now = gap && t_known;
        gap = 0;
      end else if (rv) begin
        kind = 1;
        exp_d = arr_rdata;
        tagd = r9_now ? "R9" : "R3";
      end else begin
        kind = 0;
      end
      if (wr_cap) begin
        m_addr = wr_addr; m_data = wr_data; m_poll = !wr_illegal;
      end
    end
  end

  always @(negedge clk) begin
    if (in_rst) begin
      chk("R1 dout", dout, '0);
      chk("R1 dout_oe", {7'd0, dout_oe}, 8'd0);
    end else if (kind == 0) begin
      chk("R2 dout_oe idle", {7'd0, dout_oe}, 8'd0);
      chk("R2 dout quiet", dout, '0);
    end else if (kind == 1) begin
      chk("R2 dout_oe read", {7'd0, dout_oe}, 8'd1);
      chk(tagd, dout, exp_d);
    end else begin
      chk("R2 dout_oe status", {7'd0, dout_oe}, 8'd1);
      chk(tag7, {7'd0, dout[7]}, {7'd0, exp7});
      chk("R6 reserved", {2'd0, dout[5:0]}, 8'd0);
      if (t_known) chk(r8_now ? "R8 toggle after idle" : "R5 toggle",
                       {7'd0, dout[6]}, {7'd0, ~t_last});
      t_last = dout[6];
      t_known = 1;
    end
  end

  task automatic step(input bit stb, input bit ce, input bit oe, input logic [AW-1:0] ra,
                      input logic [DW-1:0] ad, input bit bz, input bit cp, input bit il,
                      input logic [AW-1:0] wa, input logic [DW-1:0] wd);
    @(negedge clk);
    rd_stb = stb; ce_n = ce; oe_n = oe; rd_addr = ra; arr_rdata = ad;
    busy_i = bz; wr_cap = cp; wr_illegal = il; wr_addr = wa; wr_data = wd;
  endtask

  task automatic rd(input logic [AW-1:0] ra, input logic [DW-1:0] ad, input bit bz);
    step(1, 0, 0, ra, ad, bz, 0, 0, '0, '0);
  endtask

  localparam logic [AW-1:0] A0 = 17'h05555;
  localparam logic [AW-1:0] A1 = 17'h12AAA;
  localparam logic [AW-1:0] A2 = 17'h1FFFF;

  bit done = 0;

  initial begin
    #1_000_000;
    if (!done) begin
      errors++;
      $display("FAIL R1 watchdog actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R3 idle reads, R2 unqualified strobes, R7 polling before any capture
    rd(A0, 8'hA5, 0); rd(A1, 8'h5A, 0);
    step(1, 1, 0, A0, 8'hFF, 0, 0, 0, '0, '0);
    step(1, 0, 1, A0, 8'hFF, 0, 0, 0, '0, '0);
    step(0, 0, 0, A0, 8'hFF, 0, 0, 0, '0, '0);
    rd(A0, 8'h80, 1);
    // R4 legal write of 0x35, then poll during busy
    step(0, 1, 1, '0, '0, 0, 1, 0, A0, 8'h35);
    for (int i = 0; i < 4; i++) rd(A0, 8'h00, 1);
    step(1, 1, 0, A0, 8'h00, 1, 0, 0, '0, '0);   // R5 unqualified, no advance
    rd(A0, 8'h00, 1);
    rd(A1, 8'h80, 1); rd(A1, 8'h00, 1);          // R7 mismatch
    rd(A0, 8'h35, 0);                             // R3 true data after busy
    // R8 idle gap, new write 0xC2
    step(0, 1, 1, '0, '0, 0, 1, 0, A2, 8'hC2);
    rd(A2, 8'h00, 1); rd(A2, 8'h00, 1);
    // R7 illegal capture
    step(0, 1, 1, '0, '0, 0, 1, 1, A0, 8'h00);
    rd(A0, 8'h80, 1); rd(A0, 8'h00, 1);
    // R9 capture on the same edge as a read
    step(0, 1, 1, '0, '0, 0, 1, 0, A1, 8'h00);
    step(1, 0, 0, A1, 8'h00, 1, 1, 0, A1, 8'hFF);
    rd(A1, 8'h00, 1);
    // Random mix
    for (int i = 0; i < 600; i++) begin
      logic [AW-1:0] ra, wa;
      int s = $urandom_range(0, 2);
      int t = $urandom_range(0, 2);
      ra = (s == 0) ? A0 : (s == 1) ? A1 : A2;
      wa = (t == 0) ? A0 : (t == 1) ? A1 : A2;
      step($urandom_range(0, 3) != 0, $urandom_range(0, 5) == 0, $urandom_range(0, 5) == 0,
           ra, 8'($urandom), $urandom_range(0, 1) == 1, $urandom_range(0, 7) == 0,
           $urandom_range(0, 3) == 0, wa, 8'($urandom));
    end
    step(0, 1, 1, '0, '0, 0, 0, 0, '0, '0);
    repeat (3) @(negedge clk);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule